// File: doc/BRIEF.md
# Strobed Port Handshake Controller

This block runs the status side of a three-port parallel interface when port A or port B is in strobed or bidirectional operation. It watches the external control pins of port C and the host's read and write pulses to the two data ports. From these it maintains the buffer-full flags and the interrupt requests inside the port C output latch. The interrupt enables are kept in that same latch, in the bits whose positions match the strobe and acknowledge pins. The host changes those bits with a single-bit set/clear command.

Decoding the mode control word and the host address is done elsewhere. The port modes, the port B direction and one-cycle access pulses arrive here already decoded. Every update lands in the latch on the clock edge at which its cause is sampled, so `pc_latch` shows the result one cycle later.

Latch bit map: bit 0 = port B interrupt request, bit 1 = port B buffer flag (input full or output full, by direction), bit 2 = port B strobe/acknowledge position, bit 3 = port A interrupt request, bit 4 = port A strobe position, bit 5 = port A input-full flag, bit 6 = port A acknowledge position, bit 7 = port A output-full flag. The output-full flags are active low.

Top module: `strobed_hs_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_latch` becomes 0x00, and the stored previous pin sample becomes 0xFF.
- R2: When `bit_cmd_en` is high, latch bit `bit_cmd_sel` takes the value `bit_cmd_val`. A handshake update to the same bit in the same cycle overrides the command.
- R3: With `a_mode` nonzero, a falling edge on pin 4 sets latch bit 5.
- R4: With `a_mode` nonzero, a rising edge on pin 4 sets latch bit 3 only if latch bit 4 is 1. Otherwise bit 3 is untouched.
- R5: With `a_mode` nonzero, a falling edge on pin 6 sets latch bit 7. A rising edge on pin 6 sets latch bit 3 only if latch bit 6 is 1.
- R6: With `a_mode` nonzero, `a_rd` clears latch bit 5, and also bit 3 if latch bit 4 is 1. `a_wr` clears latch bit 7, and also bit 3 if latch bit 6 is 1.
- R7: With `b_strobed` high and `b_dir_in` high (input), a falling edge on pin 2 sets latch bit 1. A rising edge on pin 2 sets bit 0 if latch bit 2 is 1. `b_rd` clears bit 1, and also bit 0 if latch bit 2 is 1. `b_wr` has no effect.
- R8: With `b_strobed` high and `b_dir_in` low (output), a falling edge on pin 2 sets latch bit 1. A rising edge on pin 2 sets bit 0 if latch bit 2 is 1. `b_wr` clears bit 1, and also bit 0 if latch bit 2 is 1. `b_rd` has no effect.
- R9: An edge is a difference between the current `pc_pins` value and the value captured on the previous clock. A pin held at a steady level causes no update.
- R10: When a pin edge sets a bit and a host access clears that same bit in one cycle, the bit ends up set.
- R11: With `a_mode` = 0, pins 4 and 6 and the port A pulses leave latch bits 7..3 unchanged. With `b_strobed` low, pin 2 and the port B pulses leave bits 2..0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_mode | input | 2 | Port A mode: 0 = plain, nonzero = strobed or bidirectional |
| b_strobed | input | 1 | Port B is in strobed mode |
| b_dir_in | input | 1 | Port B direction: 1 = input, 0 = output |
| a_rd | input | 1 | One-cycle host read of port A |
| a_wr | input | 1 | One-cycle host write of port A |
| b_rd | input | 1 | One-cycle host read of port B |
| b_wr | input | 1 | One-cycle host write of port B |
| bit_cmd_en | input | 1 | Single-bit set/clear command for the latch |
| bit_cmd_sel | input | 3 | Latch bit selected by the command |
| bit_cmd_val | input | 1 | Value written by the command |
| pc_pins | input | 8 | External port C pin levels |
| pc_latch | output | 8 | Port C output latch, including status flags and enables |

## Verification
The bench targets several specific failure modes:
- The first pin sample after reset. A design whose previous-sample register resets to zero would report false rising edges on idle-high pins.
- A rising strobe with its enable bit clear. A design that ignores the enable would raise interrupts the host had masked.
- A host read coinciding with a strobe fall. If the clear won, the buffer-full flag would be lost.
- The access that does not apply to port B's current direction. A design that decodes direction wrongly would clear the flag on that access.

Finally, random stretches with random modes, pins and commands are compared every clock against a behavioural model. These catch wrong bit positions and mode gating.

// File: rtl/strobed_hs_pkg.sv
package strobed_hs_pkg;

    localparam int PC_W  = 8;
    localparam int IDX_W = $clog2(PC_W);
    localparam int LANES = 3;

    // latch bit positions (fixed by the handshake protocol)
    localparam int B_INT  = 0;
    localparam int B_FLAG = 1;
    localparam int B_CTL  = 2;
    localparam int A_INT  = 3;
    localparam int A_STB  = 4;
    localparam int A_IBF  = 5;
    localparam int A_ACK  = 6;
    localparam int A_OBF  = 7;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        pc_t set_m;
        pc_t clr_m;
    } upd_t;

    typedef struct packed {
        logic [IDX_W-1:0] flag;
        logic [IDX_W-1:0] ctl;
        logic [IDX_W-1:0] intr;
    } lane_cfg_t;

    function automatic pc_t bit_mask(input logic [IDX_W-1:0] idx);
        return pc_t'(1) << idx;
    endfunction

    // lane 0: port A strobe side, lane 1: port A acknowledge side, lane 2: port B
    function automatic lane_cfg_t lane_cfg(input int i);
        lane_cfg_t c;
        case (i)
            0:       c = '{flag: IDX_W'(A_IBF),  ctl: IDX_W'(A_STB), intr: IDX_W'(A_INT)};
            1:       c = '{flag: IDX_W'(A_OBF),  ctl: IDX_W'(A_ACK), intr: IDX_W'(A_INT)};
            default: c = '{flag: IDX_W'(B_FLAG), ctl: IDX_W'(B_CTL), intr: IDX_W'(B_INT)};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/strobed_hs_edge.sv
module strobed_hs_edge
    import strobed_hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pc_t  pins,
    output pc_t  prev,
    output pc_t  fall,
    output pc_t  rise
);
    pc_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= pins;
    end

    assign prev = prev_q;
    assign fall = prev_q & ~pins;
    assign rise = ~prev_q & pins;
endmodule

// File: rtl/strobed_hs_lane.sv
module strobed_hs_lane
    import strobed_hs_pkg::*;
#(
    parameter lane_cfg_t CFG = '0
) (
    input  logic active,
    input  logic host,
    input  pc_t  fall,
    input  pc_t  rise,
    input  pc_t  latch,
    output upd_t upd
);
    logic en;
    assign en = latch[CFG.ctl];

    always_comb begin
        upd = '0;
        if (active) begin
            if (host) begin
                upd.clr_m = upd.clr_m | bit_mask(CFG.flag);
                if (en) upd.clr_m = upd.clr_m | bit_mask(CFG.intr);
            end
            if (fall[CFG.ctl])
                upd.set_m = upd.set_m | bit_mask(CFG.flag);
            if (rise[CFG.ctl] && en)
                upd.set_m = upd.set_m | bit_mask(CFG.intr);
        end
    end
endmodule

// File: rtl/strobed_hs_ctl.sv
module strobed_hs_ctl
    import strobed_hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       a_mode,
    input  logic             b_strobed,
    input  logic             b_dir_in,
    input  logic             a_rd,
    input  logic             a_wr,
    input  logic             b_rd,
    input  logic             b_wr,
    input  logic             bit_cmd_en,
    input  logic [IDX_W-1:0] bit_cmd_sel,
    input  logic             bit_cmd_val,
    input  logic [PC_W-1:0]  pc_pins,
    output logic [PC_W-1:0]  pc_latch
);
    pc_t pin_prev, pin_fall, pin_rise;
    pc_t latch_q, base, set_all, clr_all;
    logic [LANES-1:0] lane_act, lane_host;
    upd_t lane_upd [LANES];

    strobed_hs_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pins (pc_pins),
        .prev (pin_prev),
        .fall (pin_fall),
        .rise (pin_rise)
    );

    always_comb begin
        lane_act[0]  = |a_mode;
        lane_act[1]  = |a_mode;
        lane_act[2]  = b_strobed;
        lane_host[0] = a_rd;
        lane_host[1] = a_wr;
        lane_host[2] = b_dir_in ? b_rd : b_wr;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        strobed_hs_lane #(.CFG(lane_cfg(g))) u_lane (
            .active (lane_act[g]),
            .host   (lane_host[g]),
            .fall   (pin_fall),
            .rise   (pin_rise),
            .latch  (latch_q),
            .upd    (lane_upd[g])
        );
    end

    always_comb begin
        set_all = '0;
        clr_all = '0;
        for (int i = 0; i < LANES; i++) begin
            set_all = set_all | lane_upd[i].set_m;
            clr_all = clr_all | lane_upd[i].clr_m;
        end
        base = latch_q;
        if (bit_cmd_en) base[bit_cmd_sel] = bit_cmd_val;
    end

    // order of precedence: command < host clear < pin set
    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= (base & ~clr_all) | set_all;
    end

    assign pc_latch = latch_q;
endmodule

// File: rtl/strobed_hs_ctl_chk.sv
module strobed_hs_ctl_chk
    import strobed_hs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [1:0]      a_mode,
    input logic            b_strobed,
    input logic            b_dir_in,
    input logic            a_rd,
    input logic            a_wr,
    input logic            b_rd,
    input logic            bit_cmd_en,
    input logic [PC_W-1:0] pc_pins,
    input logic [PC_W-1:0] pin_prev,
    input logic [PC_W-1:0] pc_latch
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> pc_latch == '0);

    a_r3_stb_fall_sets_ibf: assert property (@(posedge clk) disable iff (rst)
        (a_mode != 2'd0 && pin_prev[A_STB] && !pc_pins[A_STB]) |=> pc_latch[A_IBF]);

    a_r5_ack_fall_sets_obf: assert property (@(posedge clk) disable iff (rst)
        (a_mode != 2'd0 && pin_prev[A_ACK] && !pc_pins[A_ACK]) |=> pc_latch[A_OBF]);

    a_r6_write_clears_obf: assert property (@(posedge clk) disable iff (rst)
        (a_mode != 2'd0 && a_wr && !(pin_prev[A_ACK] && !pc_pins[A_ACK])) |=> !pc_latch[A_OBF]);

    a_r6_read_clears_ibf: assert property (@(posedge clk) disable iff (rst)
        (a_mode != 2'd0 && a_rd && !(pin_prev[A_STB] && !pc_pins[A_STB])) |=> !pc_latch[A_IBF]);

    a_r7_b_read_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (b_strobed && b_dir_in && b_rd && !(pin_prev[B_CTL] && !pc_pins[B_CTL])) |=> !pc_latch[B_FLAG]);

    a_r11_a_idle_in_mode0: assert property (@(posedge clk) disable iff (rst)
        (a_mode == 2'd0 && !bit_cmd_en) |=> pc_latch[7:3] == $past(pc_latch[7:3]));
endmodule

bind strobed_hs_ctl strobed_hs_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_mode     (a_mode),
    .b_strobed  (b_strobed),
    .b_dir_in   (b_dir_in),
    .a_rd       (a_rd),
    .a_wr       (a_wr),
    .b_rd       (b_rd),
    .bit_cmd_en (bit_cmd_en),
    .pc_pins    (pc_pins),
    .pin_prev   (pin_prev),
    .pc_latch   (pc_latch)
);

// File: tb/strobed_hs_ctl_test.sv
module strobed_hs_ctl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] a_mode = 2'd0;
    logic       b_strobed = 1'b0, b_dir_in = 1'b1;
    logic       a_rd = 1'b0, a_wr = 1'b0, b_rd = 1'b0, b_wr = 1'b0;
    logic       bit_cmd_en = 1'b0, bit_cmd_val = 1'b0;
    logic [2:0] bit_cmd_sel = 3'd0;
    logic [7:0] pc_pins = 8'hFF;
    logic [7:0] pc_latch;

    int checks = 0, failures = 0;
    logic [7:0] m_lat = 8'h00, m_prev = 8'hFF;

    always #2 clk = ~clk;   // 250 MHz

    strobed_hs_ctl uut (
        .clk(clk), .rst(rst), .a_mode(a_mode), .b_strobed(b_strobed), .b_dir_in(b_dir_in),
        .a_rd(a_rd), .a_wr(a_wr), .b_rd(b_rd), .b_wr(b_wr),
        .bit_cmd_en(bit_cmd_en), .bit_cmd_sel(bit_cmd_sel), .bit_cmd_val(bit_cmd_val),
        .pc_pins(pc_pins), .pc_latch(pc_latch)
    );

    // behavioural reference: next latch from current inputs
    function automatic logic [7:0] ref_next();
        logic [7:0] n, fl, rs;
        logic aon, b_acc;
        fl = m_prev & ~pc_pins;
        rs = ~m_prev & pc_pins;
        n = m_lat;
        if (bit_cmd_en) n[bit_cmd_sel] = bit_cmd_val;
        aon = (a_mode != 2'd0);
        b_acc = b_dir_in ? b_rd : b_wr;
        if (aon && a_rd) begin n[5] = 1'b0; if (m_lat[4]) n[3] = 1'b0; end
        if (aon && a_wr) begin n[7] = 1'b0; if (m_lat[6]) n[3] = 1'b0; end
        if (b_strobed && b_acc) begin n[1] = 1'b0; if (m_lat[2]) n[0] = 1'b0; end
        if (aon) begin
            if (fl[4]) n[5] = 1'b1;
            if (fl[6]) n[7] = 1'b1;
            if (rs[4] && m_lat[4]) n[3] = 1'b1;
            if (rs[6] && m_lat[6]) n[3] = 1'b1;
        end
        if (b_strobed) begin
            if (fl[2]) n[1] = 1'b1;
            if (rs[2] && m_lat[2]) n[0] = 1'b1;
        end
        return n;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one clock: inputs already set at negedge; advance model, compare after edge
    task automatic cyc(input string tag);
        logic [7:0] n;
        if (rst) begin m_lat = 8'h00; m_prev = 8'hFF; end
        else begin n = ref_next(); m_prev = pc_pins; m_lat = n; end
        @(posedge clk);
        @(negedge clk);
        check({tag, " model"}, pc_latch, m_lat);
        a_rd = 0; a_wr = 0; b_rd = 0; b_wr = 0; bit_cmd_en = 0;
    endtask

    task automatic cmd(input int b, input logic v, input string tag);
        bit_cmd_en = 1; bit_cmd_sel = 3'(b); bit_cmd_val = v;
        cyc(tag);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc("R1");
        rst = 0;
        check("R1 reset latch", pc_latch, 8'h00);

        // R2 single-bit commands
        cmd(4, 1, "R2"); cmd(6, 1, "R2");
        check("R2 set bits 4,6", pc_latch, 8'h50);
        cmd(6, 0, "R2");
        check("R2 clear bit 6", pc_latch, 8'h10);
        cmd(6, 1, "R2");

        // R9 steady pins, port A strobed
        a_mode = 2'd1;
        repeat (3) cyc("R9");
        check("R9 steady pins no change", pc_latch, 8'h50);

        pc_pins[4] = 0; cyc("R3");
        check("R3 strobe fall sets input-full", pc_latch, 8'h70);
        pc_pins[4] = 1; cyc("R4");
        check("R4 strobe rise sets intr", pc_latch, 8'h78);
        a_rd = 1; cyc("R6");
        check("R6 read clears full and intr", pc_latch, 8'h50);

        pc_pins[6] = 0; cyc("R5");
        check("R5 ack fall sets output flag", pc_latch, 8'hD0);
        pc_pins[6] = 1; cyc("R5");
        check("R5 ack rise sets intr", pc_latch, 8'hD8);
        a_wr = 1; cyc("R6");
        check("R6 write clears flag and intr", pc_latch, 8'h50);

        a_mode = 2'd2;
        cmd(4, 0, "R4");
        pc_pins[4] = 0; cyc("R4");
        pc_pins[4] = 1; cyc("R4");
        check("R4 rise with enable clear", pc_latch, 8'h60);
        a_rd = 1; cyc("R6");

        pc_pins[4] = 0; a_rd = 1; cyc("R10");
        check("R10 edge beats read", pc_latch, 8'h60);
        pc_pins[4] = 1; cyc("R10");

        a_mode = 2'd0;
        pc_pins[4] = 0; cyc("R11");
        a_wr = 1; a_rd = 1; cyc("R11");
        pc_pins[6] = 0; cyc("R11");
        check("R11 port A mode 0 idle", pc_latch, 8'h60);
        pc_pins[4] = 1; pc_pins[6] = 1; cyc("R11");

        // port B input
        pc_pins[2] = 0; cyc("R11");
        pc_pins[2] = 1; cyc("R11");
        check("R11 port B mode 0 idle", pc_latch, 8'h60);
        b_strobed = 1; b_dir_in = 1;
        cmd(2, 1, "R7");
        pc_pins[2] = 0; cyc("R7");
        pc_pins[2] = 1; cyc("R7");
        check("R7 strobe B sets flag and intr", pc_latch, 8'h67);
        b_wr = 1; cyc("R7");
        check("R7 write ignored on input", pc_latch, 8'h67);
        b_rd = 1; cyc("R7");
        check("R7 read clears B flags", pc_latch, 8'h64);

        // port B output
        b_dir_in = 0;
        pc_pins[2] = 0; cyc("R8");
        pc_pins[2] = 1; cyc("R8");
        check("R8 ack B sets flag and intr", pc_latch, 8'h67);
        b_rd = 1; cyc("R8");
        check("R8 read ignored on output", pc_latch, 8'h67);
        b_wr = 1; cyc("R8");
        check("R8 write clears B flags", pc_latch, 8'h64);

        // R2 command overridden by pin edge
        pc_pins[2] = 0; bit_cmd_en = 1; bit_cmd_sel = 3'd1; bit_cmd_val = 0; cyc("R2");
        check("R2 edge beats command", pc_latch, 8'h66);
        pc_pins[2] = 1; cyc("R2");

        // random comparison against the model
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                a_mode = 2'($urandom_range(0, 2));
                b_strobed = 1'($urandom); b_dir_in = 1'($urandom);
            end
            pc_pins = 8'($urandom);
            a_rd = ($urandom_range(0, 3) == 0); a_wr = ($urandom_range(0, 3) == 0);
            b_rd = ($urandom_range(0, 3) == 0); b_wr = ($urandom_range(0, 3) == 0);
            bit_cmd_en = ($urandom_range(0, 5) == 0);
            bit_cmd_sel = 3'($urandom); bit_cmd_val = 1'($urandom);
            cyc("R10 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule